// File: doc/BRIEF.md
# Grouped Coincidence Trigger Combiner

This block makes a first-level trigger decision from a wide bank of single-bit hit lines. The 64 hits are sampled on every clock. They are split into four groups of sixteen, called A, B, C and D. Each group is reduced to one "group active" term. A second layer then combines those four terms into pairwise and four-way OR and AND coincidences.

All twelve results appear together on a 12-bit trigger bus. Every bit has the same fixed delay, whatever function produced it. No bit is stretched or shaped. A result is high in exactly the cycles in which its condition held on the sampled hits, so its width follows the overlap of the contributing inputs.

Downstream logic picks whichever bits it needs for veto, gate or pulse shaping.

Top module: `trig_combiner`

## Requirements
- R1: Trigger bits 0, 1, 2 and 3 are the OR of hit bits 15:0 (group A), 31:16 (group B), 47:32 (group C) and 63:48 (group D) respectively.
- R2: Bit 4 is A OR B and bit 5 is C OR D.
- R3: Bit 6 is A AND B and bit 7 is C AND D.
- R4: Bit 8 is A OR C and bit 9 is B OR D.
- R5: Bit 10 is the OR of all four groups and bit 11 is the AND of all four groups.
- R6: Every trigger bit reflects the hits sampled exactly two rising clock edges earlier, and all twelve bits update on the same edge.
- R7: Output width equals input overlap. A bit is high for exactly as many cycles as its condition held. In particular, a one-cycle hit pulse gives a one-cycle output pulse on every function it satisfies.
- R8: A synchronous active-high reset clears both pipeline stages. The trigger bus is all zeros on the cycle after a reset edge and stays zero while reset is held, whatever the hits are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| hit_i | input | 64 | Hit lines, group A in the lowest 16 bits up to group D in the highest |
| trig_o | output | 12 | Combination results, bit map as in R1 to R5 |

## Verification
A hit vector driven before rising edge N is captured on that edge and its twelve results are registered on edge N+1. The results are therefore due in the half cycle after edge N+1. The scoreboard pushes the expected word when it drives a vector. At each falling edge it pops the front entry only once two words are queued, so each comparison lands exactly two edges after its stimulus. A word of zeros is preloaded at each reset release to stand for the cleared input stage. Pulse widths are totalled per bit from the same monitored samples and compared against the known overlap of the driven patterns.

// File: rtl/trig_comb_pkg.sv
package trig_comb_pkg;
    parameter int NUM_GRP = 4;
    parameter int GRP_W   = 16;
    parameter int NUM_FN  = 12;

    localparam int HIT_W = NUM_GRP * GRP_W;

    // Result bit positions on the trigger bus
    localparam int IX_A      = 0;
    localparam int IX_B      = 1;
    localparam int IX_C      = 2;
    localparam int IX_D      = 3;
    localparam int IX_AB_OR  = 4;
    localparam int IX_CD_OR  = 5;
    localparam int IX_AB_AND = 6;
    localparam int IX_CD_AND = 7;
    localparam int IX_AC_OR  = 8;
    localparam int IX_BD_OR  = 9;
    localparam int IX_ANY    = 10;
    localparam int IX_ALL    = 11;
endpackage

// File: rtl/tc_pipe_reg.sv
module tc_pipe_reg #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q_o <= '0;
        end else begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/tc_group_or.sv
module tc_group_or #(
    parameter int NG = 4,
    parameter int GW = 16
) (
    input  logic [NG*GW-1:0] hit_i,
    output logic [NG-1:0]    grp_o
);
    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign grp_o[g] = |hit_i[g*GW +: GW];
    end
endmodule

// File: rtl/tc_combine_net.sv
module tc_combine_net
    import trig_comb_pkg::*;
(
    input  logic [NUM_GRP-1:0] grp_i,
    output logic [NUM_FN-1:0]  fn_o
);
    logic a, b, c, d;

    assign a = grp_i[0];
    assign b = grp_i[1];
    assign c = grp_i[2];
    assign d = grp_i[3];

    always_comb begin
        fn_o            = '0;
        fn_o[IX_A]      = a;
        fn_o[IX_B]      = b;
        fn_o[IX_C]      = c;
        fn_o[IX_D]      = d;
        fn_o[IX_AB_OR]  = a | b;
        fn_o[IX_CD_OR]  = c | d;
        fn_o[IX_AB_AND] = a & b;
        fn_o[IX_CD_AND] = c & d;
        fn_o[IX_AC_OR]  = a | c;
        fn_o[IX_BD_OR]  = b | d;
        fn_o[IX_ANY]    = |grp_i;
        fn_o[IX_ALL]    = &grp_i;
    end
endmodule

// File: rtl/trig_combiner.sv
module trig_combiner
    import trig_comb_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [HIT_W-1:0]  hit_i,
    output logic [NUM_FN-1:0] trig_o
);
    logic [HIT_W-1:0]   hit_q;
    logic [NUM_GRP-1:0] grp_act;
    logic [NUM_FN-1:0]  fn_comb;

    // Stage 1: capture hits
    tc_pipe_reg #(.W(HIT_W)) u_in_stage (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (hit_i),
        .q_o   (hit_q)
    );

    tc_group_or #(.NG(NUM_GRP), .GW(GRP_W)) u_group_or (
        .hit_i (hit_q),
        .grp_o (grp_act)
    );

    tc_combine_net u_combine (
        .grp_i (grp_act),
        .fn_o  (fn_comb)
    );

    // Stage 2: align all results on one edge
    tc_pipe_reg #(.W(NUM_FN)) u_out_stage (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (fn_comb),
        .q_o   (trig_o)
    );
endmodule

// File: rtl/tc_trig_checker.sv
module tc_trig_checker
    import trig_comb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [HIT_W-1:0]  hit,
    input logic [NUM_FN-1:0] trig
);
    logic [HIT_W-1:0]   hit_d1, hit_d2;
    logic [1:0]         since_rst;
    logic [NUM_GRP-1:0] grp_d2;
    logic               warm;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 2'd2) begin
            since_rst <= since_rst + 2'd1;
        end
        hit_d1 <= hit;
        hit_d2 <= hit_d1;
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_ref
        assign grp_d2[g] = |hit_d2[g*GRP_W +: GRP_W];
    end

    assign warm = (since_rst == 2'd2);

    p_group_or_r1: assert property (@(posedge clk) disable iff (rst)
        warm |-> (trig[3:0] == grp_d2));

    p_pair_or_r2: assert property (@(posedge clk) disable iff (rst)
        (trig[IX_AB_OR] == (trig[IX_A] | trig[IX_B])) &&
        (trig[IX_CD_OR] == (trig[IX_C] | trig[IX_D])));

    p_pair_and_r3: assert property (@(posedge clk) disable iff (rst)
        (trig[IX_AB_AND] == (trig[IX_A] & trig[IX_B])) &&
        (trig[IX_CD_AND] == (trig[IX_C] & trig[IX_D])));

    p_cross_or_r4: assert property (@(posedge clk) disable iff (rst)
        (trig[IX_AC_OR] == (trig[IX_A] | trig[IX_C])) &&
        (trig[IX_BD_OR] == (trig[IX_B] | trig[IX_D])));

    p_wide_r5: assert property (@(posedge clk) disable iff (rst)
        (trig[IX_ANY] == (|trig[3:0])) && (trig[IX_ALL] == (&trig[3:0])));

    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        warm |-> (trig[IX_ANY] == (|hit_d2)));

    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (trig == '0));
endmodule

bind trig_combiner tc_trig_checker u_chk (
    .clk  (clk_i),
    .rst  (rst_i),
    .hit  (hit_i),
    .trig (trig_o)
);

// File: tb/trig_combiner_tb.sv
module trig_combiner_tb;
    import trig_comb_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [HIT_W-1:0]  hit = '0;
    logic [NUM_FN-1:0] trig;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    int wcnt [NUM_FN];
    logic [NUM_FN-1:0] expq [$];

    trig_combiner u_dut (
        .clk_i  (clk),
        .rst_i  (rst),
        .hit_i  (hit),
        .trig_o (trig)
    );

    always #5 clk = ~clk;

    function automatic logic [NUM_FN-1:0] model(input logic [HIT_W-1:0] v);
        logic a, b, c, d;
        a = |v[15:0];
        b = |v[31:16];
        c = |v[47:32];
        d = |v[63:48];
        return {a & b & c & d, a | b | c | d, b | d, a | c,
                c & d, a & b, c | d, a | b, d, c, b, a};
    endfunction

    function automatic string tag(input int i);
        if (i < 4) return "R1";
        if (i < 6) return "R2";
        if (i < 8) return "R3";
        if (i < 10) return "R4";
        return "R5";
    endfunction

    task automatic check(input string req, input int act, input int exp_v);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // Driver with scoreboard: expected word pushed at drive time, popped two edges later (R6)
    task automatic step(input logic [HIT_W-1:0] v);
        logic [NUM_FN-1:0] e;
        @(negedge clk);
        if (expq.size() == 2) begin
            e = expq.pop_front();
            total++;
            if (trig !== e) begin
                bad++;
                for (int i = 0; i < NUM_FN; i++) begin
                    if (trig[i] !== e[i])
                        $display("FAIL %s/R6 bit%0d actual=%0h expected=%0h",
                                 tag(i), i, trig, e);
                end
            end
            for (int i = 0; i < NUM_FN; i++) if (trig[i] === 1'b1) wcnt[i]++;
        end
        hit = v;
        expq.push_back(model(v));
    endtask

    task automatic clear_widths();
        for (int i = 0; i < NUM_FN; i++) wcnt[i] = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        hit = '1;
        expq.delete();
        @(negedge clk);
        check("R8 after reset edge", int'(trig), 0);
        repeat (2) @(negedge clk);
        check("R8 while held", int'(trig), 0);
        rst = 1'b0;
        hit = '0;
        expq.push_back('0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clear_widths();
        do_reset();

        // R1: edge bits of each group, one group at a time
        for (int g = 0; g < NUM_GRP; g++) begin
            step(64'd1 << (g * GRP_W));
            step(64'd1 << (g * GRP_W + GRP_W - 1));
        end
        // R2/R3/R4: pairs and mixed patterns
        step(64'h0000_0000_0001_0001);
        step(64'h0001_0001_0000_0000);
        step(64'h0000_8000_0000_8000);
        step(64'h8000_0000_0000_8000);
        step(64'h0000_0000_0000_0000);
        // R5: all groups, then three of four
        step(64'hFFFF_FFFF_FFFF_FFFF);
        step(64'h0010_0200_3000_0004);
        step(64'h0000_0200_3000_0004);
        step(64'hA5A5_0000_5A5A_0000);
        step('0);
        step('0);
        step('0);

        // R7: A held five cycles, B overlaps for three of them
        clear_widths();
        step(64'h0000_0000_0000_0008);
        step(64'h0000_0000_0010_0008);
        step(64'h0000_0000_0010_0008);
        step(64'h0000_0000_0010_0008);
        step(64'h0000_0000_0000_0008);
        repeat (3) step('0);
        check("R7 A&B width", wcnt[IX_AB_AND], 3);
        check("R7 A|B width", wcnt[IX_AB_OR], 5);
        check("R7 B width", wcnt[IX_B], 3);

        // R7: single-cycle pulse on every group
        clear_widths();
        step(64'h0001_0001_0001_0001);
        repeat (3) step('0);
        check("R7 all-and single pulse", wcnt[IX_ALL], 1);
        check("R7 any single pulse", wcnt[IX_ANY], 1);
        check("R7 C|D single pulse", wcnt[IX_CD_OR], 1);

        // R8: reset mid-stream, then scoreboard resumes
        step(64'hFFFF_FFFF_FFFF_FFFF);
        do_reset();
        step(64'h0000_0001_0000_0000);
        step(64'h0001_0000_0001_0000);
        repeat (3) step('0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule